// File: doc/BRIEF.md
# Idle Mode and Reset Qualifier

This block sits beside a small 8-bit microcontroller core. It controls the core's low-power idle state and gathers the core's reset sources into one reset. A free-running machine-cycle phase counter produces a peripheral clock enable once per machine cycle. The core clock enable is the same pulse, gated off while the block is idle or in reset. While idle, the peripheral enable keeps running, so the interrupt, timer, watchdog and serial logic stay alive. The bus strobes (address latch enable and program store enable) are forced high.

Software marks an idle request by writing 1 to the idle control bit. Idle begins when the current instruction reports completion. An enabled interrupt ends idle, clears the idle bit and gives a one-clock wake pulse. A watchdog time-out does the same.

The reset side has three sources. The first is the external reset pin, accepted only after a minimum high time. The second is power-on. The third is a watchdog time-out that software fails to clear within a fixed delay. These sources are merged into one synchronous reset. That reset is stretched by one machine cycle, cancels idle and realigns the machine-cycle phase.

Top module: `idle_rst_ctrl`

## Requirements
- R1: A pulse on `idle_set_i` marks idle as pending without stopping the core. The state becomes idle (`idle_o` = 1) at the first later clock edge that samples `instr_done_i` high.
- R2: While `idle_o` is 1, `core_ce_o` stays 0. `periph_ce_o` keeps pulsing once every CLKS_PER_MC clocks.
- R3: Outside reset, `periph_ce_o` is high for one clock in every CLKS_PER_MC clocks. `core_ce_o` equals `periph_ce_o` whenever the block is neither idle nor in reset.
- R4: `strobe_hold_o` is 1 exactly while the block is idle.
- R5: Suppose `irq_i` or `wdt_timeout_i` is high at an edge while the block is idle and not in reset. Then idle ends at that edge, and `wake_o` is high for exactly the following clock. `wake_o` never pulses when the block was not idle.
- R6: The reset pin qualifier needs QUAL = CLKS_PER_MC*RST_QUAL_MC consecutive high samples (default 8). `rst_o` rises at the QUAL+1-th edge after the pin goes high. Any low sample restarts the count, so a shorter pulse has no effect.
- R7: Without a clear, a sampled watchdog time-out makes `rst_o` rise at the WDT_RST_DELAY+1-th edge after it (default 513). A sampled `wdt_clear_i` cancels the pending reset, and it takes priority over a time-out in the same cycle.
- R8: `rst_o` is high while `por_i` is high and while any reset source is valid. It stays high for CLKS_PER_MC clocks after the last edge at which a source is seen.
- R9: While `rst_o` is high, the block is not idle and a pending idle request is cancelled, and `wake_o` stays 0. The phase counter is held at zero, so the first `periph_ce_o` after reset falls in the CLKS_PER_MC-th clock with `rst_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| rst_pin_i | input | 1 | External reset pin level, active high |
| idle_set_i | input | 1 | Software write of 1 to the idle control bit |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| irq_i | input | 1 | An enabled interrupt is requesting service |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| wdt_clear_i | input | 1 | Software restarts the watchdog |
| core_ce_o | output | 1 | Core clock enable (machine-cycle tick) |
| periph_ce_o | output | 1 | Peripheral clock enable (machine-cycle tick) |
| strobe_hold_o | output | 1 | Forces address latch and program store strobes high |
| idle_o | output | 1 | Idle control bit state |
| wake_o | output | 1 | One-clock pulse when idle ends through a wake source |
| rst_o | output | 1 | Merged synchronous reset |

## Verification
Directed sequences cover the timing edges. The pin filter gets a 7-clock high pulse, two 5-clock bursts split by one low sample, and a long hold. These separate a correct restart-on-low counter from one that only counts total high time, and they pin the exact rise and release edges. Watchdog runs compare an uncleared time-out, a cleared one and a simultaneous clear and time-out, which separates the 513-edge delay and the clear priority from off-by-one variants. Idle is entered and left by interrupt, by watchdog time-out and by reset. Long random stretches then mix all inputs against a cycle model, exposing wrong priorities between reset, wake and idle entry.

// File: rtl/idle_rst_pkg.sv
package idle_rst_pkg;

   // power state of the core clock gate
   typedef enum logic [1:0] {
      PWR_RUN  = 2'd0,
      PWR_PEND = 2'd1,
      PWR_IDLE = 2'd2
   } pwr_state_e;

endpackage

// File: rtl/mc_phase_gen.sv
module mc_phase_gen #(
   parameter int CLKS = 4
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic hold_i,
   output logic tick_o
);

   generate
      if (CLKS < 1) begin : g_bad_clks
         $error("mc_phase_gen: CLKS must be at least 1");
      end

      if (CLKS == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int PW = $clog2(CLKS);
         localparam logic [PW-1:0] LAST = PW'(CLKS - 1);

         logic [PW-1:0] ph_q;

         always_ff @(posedge clk_i) begin
            if (por_i || hold_i) begin
               ph_q <= '0;
            end else if (ph_q == LAST) begin
               ph_q <= '0;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
         end

         assign tick_o = (ph_q == LAST);

         // R3
         tick_single_chk: assert property (@(posedge clk_i) disable iff (por_i)
            tick_o |=> !tick_o);

         // R9
         hold_clears_phase_chk: assert property (@(posedge clk_i) disable iff (por_i)
            hold_i |=> !tick_o);
      end
   endgenerate

endmodule

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
   parameter int QUAL = 8
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic pin_i,
   output logic valid_o
);

   localparam int HW = $clog2(QUAL + 1);
   localparam logic [HW-1:0] FULL = HW'(QUAL);

   logic [HW-1:0] hi_q;

   generate
      if (QUAL < 1) begin : g_bad_qual
         $error("rst_pin_qual: QUAL must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (por_i || !pin_i) begin
         hi_q <= '0;
      end else if (hi_q != FULL) begin
         hi_q <= hi_q + 1'b1;
      end
   end

   assign valid_o = (hi_q == FULL);

   // R6
   low_restarts_chk: assert property (@(posedge clk_i) disable iff (por_i)
      !pin_i |=> !valid_o);

   // R6
   valid_needs_pin_chk: assert property (@(posedge clk_i) disable iff (por_i)
      valid_o |-> $past(pin_i));

endmodule

// File: rtl/wdt_rst_delay.sv
module wdt_rst_delay #(
   parameter int DELAY = 512
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic rst_i,
   input  logic timeout_i,
   input  logic clear_i,
   output logic fire_o
);

   localparam int CW = $clog2(DELAY);
   localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

   logic          armed_q;
   logic [CW-1:0] cnt_q;

   generate
      if (DELAY < 2) begin : g_bad_delay
         $error("wdt_rst_delay: DELAY must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (por_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (rst_i || clear_i) begin
         armed_q <= 1'b0;
      end else if (timeout_i) begin
         armed_q <= 1'b1;
         cnt_q   <= LOAD;
      end else if (armed_q) begin
         if (cnt_q == '0) begin
            armed_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign fire_o = armed_q && (cnt_q == '0) && !clear_i;

   // R7
   clear_cancels_chk: assert property (@(posedge clk_i) disable iff (por_i)
      clear_i |=> !fire_o);

   // R7
   no_early_fire_chk: assert property (@(posedge clk_i) disable iff (por_i)
      (timeout_i && !clear_i && !rst_i) |=> !fire_o);

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
   parameter int HOLD = 4
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic src_i,
   output logic rst_o
);

   localparam int HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] FULL = HW'(HOLD);
   localparam logic [HW-1:0] ONE  = HW'(1);

   logic          rst_q;
   logic [HW-1:0] cnt_q;

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("rst_stretch: HOLD must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (por_i || src_i) begin
         rst_q <= 1'b1;
         cnt_q <= FULL;
      end else if (cnt_q > ONE) begin
         cnt_q <= cnt_q - 1'b1;
      end else begin
         rst_q <= 1'b0;
         cnt_q <= '0;
      end
   end

   assign rst_o = rst_q;

   // R8
   src_asserts_chk: assert property (@(posedge clk_i) disable iff (por_i)
      src_i |=> rst_o);

   // R8
   release_quiet_chk: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(rst_o) |-> !$past(src_i));

endmodule

// File: rtl/idle_state_ctrl.sv
module idle_state_ctrl
   import idle_rst_pkg::*;
(
   input  logic clk_i,
   input  logic por_i,
   input  logic rst_i,
   input  logic set_i,
   input  logic done_i,
   input  logic wake_req_i,
   output logic idle_o,
   output logic wake_o
);

   pwr_state_e st_q;
   logic       wake_q;

   always_ff @(posedge clk_i) begin
      if (por_i) begin
         st_q   <= PWR_RUN;
         wake_q <= 1'b0;
      end else begin
         wake_q <= 1'b0;
         if (rst_i) begin
            st_q <= PWR_RUN;
         end else begin
            case (st_q)
               PWR_RUN:  if (set_i)  st_q <= PWR_PEND;
               PWR_PEND: if (done_i) st_q <= PWR_IDLE;
               PWR_IDLE: if (wake_req_i) begin
                  st_q   <= PWR_RUN;
                  wake_q <= 1'b1;
               end
               default:  st_q <= PWR_RUN;
            endcase
         end
      end
   end

   assign idle_o = (st_q == PWR_IDLE);
   assign wake_o = wake_q;

   // R1
   entry_on_done_chk: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(idle_o) |-> $past(done_i));

   // R5
   wake_exits_chk: assert property (@(posedge clk_i) disable iff (por_i)
      (idle_o && wake_req_i && !rst_i) |=> (!idle_o && wake_o));

   // R9
   reset_exits_chk: assert property (@(posedge clk_i) disable iff (por_i)
      rst_i |=> (!idle_o && !wake_o));

endmodule

// File: rtl/idle_rst_ctrl.sv
module idle_rst_ctrl #(
   parameter int CLKS_PER_MC   = 4,
   parameter int RST_QUAL_MC   = 2,
   parameter int WDT_RST_DELAY = 512
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic rst_pin_i,
   input  logic idle_set_i,
   input  logic instr_done_i,
   input  logic irq_i,
   input  logic wdt_timeout_i,
   input  logic wdt_clear_i,
   output logic core_ce_o,
   output logic periph_ce_o,
   output logic strobe_hold_o,
   output logic idle_o,
   output logic wake_o,
   output logic rst_o
);

   localparam int QUAL = CLKS_PER_MC * RST_QUAL_MC;
   localparam int HOLD = CLKS_PER_MC;

   generate
      if (CLKS_PER_MC < 1 || RST_QUAL_MC < 1) begin : g_bad_cfg
         $error("idle_rst_ctrl: machine cycle and qualify length must be positive");
      end
   endgenerate

   logic tick;
   logic pin_valid;
   logic wdt_fire;
   logic rst_src;
   logic idle_q;

   mc_phase_gen #(.CLKS(CLKS_PER_MC)) u_phase (
      .clk_i  (clk_i),
      .por_i  (por_i),
      .hold_i (rst_o),
      .tick_o (tick)
   );

   rst_pin_qual #(.QUAL(QUAL)) u_pin (
      .clk_i   (clk_i),
      .por_i   (por_i),
      .pin_i   (rst_pin_i),
      .valid_o (pin_valid)
   );

   wdt_rst_delay #(.DELAY(WDT_RST_DELAY)) u_wdt (
      .clk_i     (clk_i),
      .por_i     (por_i),
      .rst_i     (rst_o),
      .timeout_i (wdt_timeout_i),
      .clear_i   (wdt_clear_i),
      .fire_o    (wdt_fire)
   );

   assign rst_src = pin_valid | wdt_fire;

   rst_stretch #(.HOLD(HOLD)) u_hold (
      .clk_i (clk_i),
      .por_i (por_i),
      .src_i (rst_src),
      .rst_o (rst_o)
   );

   idle_state_ctrl u_idle (
      .clk_i      (clk_i),
      .por_i      (por_i),
      .rst_i      (rst_o),
      .set_i      (idle_set_i),
      .done_i     (instr_done_i),
      .wake_req_i (irq_i | wdt_timeout_i),
      .idle_o     (idle_q),
      .wake_o     (wake_o)
   );

   assign idle_o        = idle_q;
   assign strobe_hold_o = idle_q;
   assign periph_ce_o   = tick;
   assign core_ce_o     = tick & ~idle_q & ~rst_o;

endmodule

// File: tb/idle_rst_ctrl_bench.sv
module idle_rst_ctrl_bench;

   localparam int N    = 4;
   localparam int QMC  = 2;
   localparam int DLY  = 512;
   localparam int QUAL = N * QMC;
   localparam int HOLD = N;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic por, pin, iset, done, irq, wto, wclr;
   logic core_ce, periph_ce, strobe, idle, wake, rst;

   idle_rst_ctrl #(.CLKS_PER_MC(N), .RST_QUAL_MC(QMC), .WDT_RST_DELAY(DLY)) u_idle_rst_ctrl (
      .clk_i(clk), .por_i(por), .rst_pin_i(pin), .idle_set_i(iset),
      .instr_done_i(done), .irq_i(irq), .wdt_timeout_i(wto), .wdt_clear_i(wclr),
      .core_ce_o(core_ce), .periph_ce_o(periph_ce), .strobe_hold_o(strobe),
      .idle_o(idle), .wake_o(wake), .rst_o(rst)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit chk_en = 1'b0;
   bit finished = 1'b0;

   task automatic expect_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // cycle model built from the requirements
   int m_ph, m_st, m_hi, m_arm, m_wc, m_rst, m_hold, m_wake;

   always @(posedge clk) begin
      int fire, src, nst, nwake;
      if (por) begin
         m_ph = 0; m_st = 0; m_hi = 0; m_arm = 0; m_wc = 0;
         m_rst = 1; m_hold = HOLD; m_wake = 0;
      end else begin
         fire = (m_arm != 0 && m_wc == 0 && !wclr) ? 1 : 0;
         src  = (m_hi == QUAL || fire != 0) ? 1 : 0;
         m_ph = (m_rst != 0) ? 0 : ((m_ph == N - 1) ? 0 : m_ph + 1);
         m_hi = pin ? ((m_hi == QUAL) ? QUAL : m_hi + 1) : 0;
         if (m_rst != 0 || wclr) m_arm = 0;
         else if (wto) begin m_arm = 1; m_wc = DLY - 1; end
         else if (m_arm != 0) begin
            if (m_wc == 0) m_arm = 0; else m_wc = m_wc - 1;
         end
         nwake = 0;
         nst = m_st;
         if (m_rst != 0) nst = 0;
         else if (m_st == 2 && (irq || wto)) begin nst = 0; nwake = 1; end
         else if (m_st == 1 && done) nst = 2;
         else if (m_st == 0 && iset) nst = 1;
         m_st = nst;
         m_wake = nwake;
         if (src != 0) begin m_rst = 1; m_hold = HOLD; end
         else if (m_hold > 1) m_hold = m_hold - 1;
         else begin m_rst = 0; m_hold = 0; end
      end
   end

   always @(negedge clk) begin
      if (chk_en) begin
         int e_tick;
         e_tick = (m_ph == N - 1) ? 1 : 0;
         expect_eq("R3 periph_ce model", int'(periph_ce), e_tick);
         expect_eq("R2 core_ce model", int'(core_ce),
                   (e_tick != 0 && m_st != 2 && m_rst == 0) ? 1 : 0);
         expect_eq("R4 strobe_hold model", int'(strobe), (m_st == 2) ? 1 : 0);
         expect_eq("R1 idle model", int'(idle), (m_st == 2) ? 1 : 0);
         expect_eq("R5 wake model", int'(wake), m_wake);
         expect_eq("R8 rst model", int'(rst), m_rst);
      end
   end

   task automatic enter_idle();
      iset = 1'b1; step(1); iset = 1'b0;
      step(2);
      done = 1'b1; step(1); done = 1'b0;
   endtask

   initial begin
      int first, seen, pt, ct;
      por = 1'b1; pin = 1'b0; iset = 1'b0; done = 1'b0;
      irq = 1'b0; wto = 1'b0; wclr = 1'b0;
      step(3);
      expect_eq("R8 rst during power-on", int'(rst), 1);
      expect_eq("R9 idle during power-on", int'(idle), 0);
      expect_eq("R2 core_ce during power-on", int'(core_ce), 0);
      expect_eq("R5 wake during power-on", int'(wake), 0);
      chk_en = 1'b1;
      por = 1'b0;
      step(3);
      expect_eq("R8 rst held after power-on", int'(rst), 1);
      step(1);
      expect_eq("R8 rst released after power-on", int'(rst), 0);
      first = 0;
      for (int k = 1; k <= 6; k++) begin
         step(1);
         if (periph_ce && first == 0) first = k;
      end
      expect_eq("R9 first tick after reset", first, N - 1);

      // R1 R2 R4 R5: idle entry and interrupt wake
      iset = 1'b1; step(1); iset = 1'b0;
      expect_eq("R1 pending is not idle", int'(idle), 0);
      step(5);
      expect_eq("R1 no idle before done", int'(idle), 0);
      done = 1'b1; step(1); done = 1'b0;
      expect_eq("R1 idle after done", int'(idle), 1);
      expect_eq("R4 strobes held in idle", int'(strobe), 1);
      pt = 0; ct = 0;
      for (int k = 0; k < 12; k++) begin
         step(1);
         pt += int'(periph_ce);
         ct += int'(core_ce);
      end
      expect_eq("R2 periph ticks in idle", pt, 12 / N);
      expect_eq("R2 core ticks in idle", ct, 0);
      irq = 1'b1; step(1); irq = 1'b0;
      expect_eq("R5 idle ends on irq", int'(idle), 0);
      expect_eq("R5 wake pulse", int'(wake), 1);
      step(1);
      expect_eq("R5 wake one clock", int'(wake), 0);
      irq = 1'b1; step(1); irq = 1'b0;
      expect_eq("R5 no wake outside idle", int'(wake), 0);

      // R6: short pulse, restarted count, long hold
      pin = 1'b1; step(QUAL - 1); pin = 1'b0;
      seen = 0;
      for (int k = 0; k < 20; k++) begin step(1); seen |= int'(rst); end
      expect_eq("R6 short pulse ignored", seen, 0);
      pin = 1'b1; step(5); pin = 1'b0; step(1); pin = 1'b1; step(5); pin = 1'b0;
      seen = 0;
      for (int k = 0; k < 20; k++) begin step(1); seen |= int'(rst); end
      expect_eq("R6 count restarts on low", seen, 0);
      pin = 1'b1; first = 0;
      for (int k = 1; k <= 20; k++) begin
         step(1);
         if (rst && first == 0) first = k;
      end
      expect_eq("R6 rise edge after pin high", first, QUAL + 1);
      pin = 1'b0;
      step(HOLD);
      expect_eq("R8 held after pin drop", int'(rst), 1);
      step(1);
      expect_eq("R8 released after pin drop", int'(rst), 0);
      step(8);

      // R9: reset leaves idle and cancels a pending request
      enter_idle();
      expect_eq("R9 idle before reset", int'(idle), 1);
      pin = 1'b1; step(QUAL + 2);
      expect_eq("R9 rst active", int'(rst), 1);
      expect_eq("R9 idle cleared by reset", int'(idle), 0);
      expect_eq("R9 no wake on reset", int'(wake), 0);
      pin = 1'b0; step(10);
      iset = 1'b1; step(1); iset = 1'b0;
      pin = 1'b1; step(QUAL + 2); pin = 1'b0; step(HOLD + 2);
      done = 1'b1; step(1); done = 1'b0;
      expect_eq("R9 pending cancelled by reset", int'(idle), 0);
      step(4);

      // R5 R7: watchdog wake then delayed reset
      enter_idle();
      wto = 1'b1; step(1); wto = 1'b0;
      expect_eq("R5 watchdog wakes", int'(wake), 1);
      expect_eq("R5 watchdog ends idle", int'(idle), 0);
      first = (rst) ? 1 : 0;
      for (int k = 2; k <= DLY + 40; k++) begin
         step(1);
         if (rst && first == 0) first = k;
      end
      expect_eq("R7 reset after watchdog delay", first, DLY + 1);
      wto = 1'b1; step(1); wto = 1'b0;
      step(200);
      wclr = 1'b1; step(1); wclr = 1'b0;
      seen = 0;
      for (int k = 0; k < DLY + 100; k++) begin step(1); seen |= int'(rst); end
      expect_eq("R7 clear cancels reset", seen, 0);
      wto = 1'b1; wclr = 1'b1; step(1); wto = 1'b0; wclr = 1'b0;
      seen = 0;
      for (int k = 0; k < DLY + 100; k++) begin step(1); seen |= int'(rst); end
      expect_eq("R7 clear beats time-out", seen, 0);

      // random mix against the model
      void'($urandom(32'd20051020));
      for (int i = 0; i < 30000; i++) begin
         if (pin) pin = ($urandom_range(5) != 0);
         else     pin = ($urandom_range(299) == 0);
         iset = ($urandom_range(39) == 0);
         done = ($urandom_range(4) == 0);
         irq  = ($urandom_range(29) == 0);
         wto  = ($urandom_range(2999) == 0);
         wclr = ($urandom_range(799) == 0);
         step(1);
      end
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule